// File: doc/BRIEF.md
# Fixed Latency Bunch Accept/Reject Delay

This block produces the backward-compatible veto level for detector front ends. It gives one accept/reject level per bunch at the bunch rate. On every bunch strobe it samples a decision bit. It then shows that decision on its output after a fixed latency: a coarse part of n whole bunch periods plus a fine part of Δt fast-clock cycles. Both parts apply the same way to accepted and rejected bunches, so the front end sees an identical delay for every bunch.

The block runs on the fast clock, which gives 22 cycles per bunch period. The bunch strobe is a one-cycle pulse once per period. A history register holds the most recent decisions, and the coarse delay picks one of its taps. The selected decision then waits in a pending register until a fast-clock down-counter, loaded with the fine delay, runs out. The coarse and fine settings are sampled only on a strobe, so a change made between strobes takes effect at the next strobe.

Top module: `bunch_accept_delay`

## Requirements
- R1: The decision is sampled only on a fast-clock edge where bunchStb is high (1 = accept, 0 = reject). Its value on all other cycles has no effect on acceptOut.
- R2: acceptOut changes only on a strobe edge with zero fine delay, or on the edge where a pending fine delay runs out. It holds its value on every other cycle.
- R3: Number the strobe edges k. The decision sampled at strobe k drives acceptOut from the edge that lies Δt fast-clock cycles after strobe k+n, where n and Δt are the values sampled at strobe k+n. With strobes every 22 cycles this is a latency of n·22+Δt cycles for both accept and reject.
- R4: When Δt is 0, acceptOut takes the selected decision on the strobe edge itself.
- R5: A fine delay above 21 (fineDelay 22 to 31) acts as 21.
- R6: n may be any value from 0 to 15. With n = 0, acceptOut shows the decision sampled at the same strobe.
- R7: During and after reset acceptOut is 1. Any tap that refers to a strobe before reset yields 1 (accept).
- R8: coarseDelay and fineDelay are sampled only on a strobe edge. A change made between strobes has no effect until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, 22 cycles per bunch period |
| rst_n | input | 1 | Active-low synchronous reset |
| bunchStb | input | 1 | One-cycle bunch strobe, once per bunch period |
| decisionIn | input | 1 | Decision for the current bunch: 1 accept, 0 reject |
| coarseDelay | input | 4 | n, the delay in whole bunch periods (0 to 15) |
| fineDelay | input | 5 | Δt, the fine delay in fast-clock cycles (clamped to 21) |
| acceptOut | output | 1 | Delayed accept/reject level |

## Verification
The assertions assume that strobes come at least two cycles apart and that the design is out of reset. Under those conditions an armed fine counter always fires once before it is reloaded. The bench keeps to these conditions by sending strobes exactly every 22 cycles, which is one more than the largest clamped fine delay, so no new strobe ever meets a pending update. It changes the decision and the delay settings only between strobes, in order to show that those changes have no effect until the next strobe.

// File: rtl/bunch_accept_delay_pkg.sv
package bunch_accept_delay_pkg;

  // Strobes from the control side to the datapath.
  typedef struct packed {
    logic capture;    // bunch strobe: shift history, load pending value
    logic immediate;  // capture with zero fine delay: update output now
    logic fire;       // fine delay has run out: present pending value
  } ctlStrb_t;

endpackage

// File: rtl/bunch_accept_delay_ctrl.sv
module bunch_accept_delay_ctrl
  import bunch_accept_delay_pkg::*;
#(
  parameter int PERIOD = 22,
  parameter int DEPTH  = 16,
  localparam int CW    = $clog2(DEPTH),
  localparam int FW    = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bunchStb,
  input  logic [CW-1:0] coarseDelay,
  input  logic [FW-1:0] fineDelay,
  output ctlStrb_t      strb,
  output logic [CW-1:0] tapSel
);

  localparam logic [FW-1:0] MAX_FINE = FW'(PERIOD - 1);
  localparam logic [CW-1:0] MAX_TAP  = CW'(DEPTH - 1);

  logic [FW-1:0] fineEff;
  logic [FW-1:0] cnt;
  logic          armed;

  // Clamp the fine delay so that it always ends inside one bunch period.
  assign fineEff = (fineDelay > MAX_FINE) ? MAX_FINE : fineDelay;

  // Clamp the tap only when the select width can exceed the history.
  generate
    if (DEPTH == (1 << CW)) begin : g_tapFull
      assign tapSel = coarseDelay;
    end else begin : g_tapClamp
      assign tapSel = (coarseDelay > MAX_TAP) ? MAX_TAP : coarseDelay;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (bunchStb) begin
      cnt   <= fineEff;
      armed <= (fineEff != '0);
    end else if (armed) begin
      cnt <= cnt - 1'b1;
      if (cnt == FW'(1)) armed <= 1'b0;
    end
  end

  always_comb begin
    strb.capture   = bunchStb;
    strb.immediate = bunchStb && (fineEff == '0);
    strb.fire      = armed && (cnt == FW'(1));
  end

  AST_ARM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (cnt != '0 && cnt <= MAX_FINE)); // R5

  AST_LOAD_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (bunchStb && fineEff != '0) |=> (armed && cnt == $past(fineEff))); // R8

  AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.fire && !bunchStb) |=> !strb.fire); // R3

endmodule

// File: rtl/bunch_accept_delay_dpath.sv
module bunch_accept_delay_dpath
  import bunch_accept_delay_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH),
  localparam int HW   = DEPTH - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctlStrb_t      strb,
  input  logic          decisionIn,
  input  logic [CW-1:0] tapSel,
  output logic          acceptOut
);

  logic [HW-1:0] hist;
  logic          tapBit;
  logic          pendVal;

  // History of earlier decisions; stage 0 is the previous strobe.
  generate
    for (genvar g = 0; g < HW; g++) begin : g_hist
      if (g == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rst_n)            hist[g] <= 1'b1;
          else if (strb.capture) hist[g] <= decisionIn;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (!rst_n)            hist[g] <= 1'b1;
          else if (strb.capture) hist[g] <= hist[g-1];
        end
      end
    end
  endgenerate

  // Tap 0 is the decision arriving now; tap i is i strobes back.
  always_comb begin
    tapBit = decisionIn;
    for (int i = 1; i < DEPTH; i++) begin
      if (tapSel == CW'(i)) tapBit = hist[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendVal   <= 1'b1;
      acceptOut <= 1'b1;
    end else begin
      if (strb.fire)      acceptOut <= pendVal;
      if (strb.capture)   pendVal   <= tapBit;
      if (strb.immediate) acceptOut <= tapBit;
    end
  end

  AST_HIST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capture |=> hist[0] == $past(decisionIn)); // R1

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.capture |=> hist == $past(hist)); // R1

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.fire || strb.immediate) |=> acceptOut == $past(acceptOut)); // R2

endmodule

// File: rtl/bunch_accept_delay.sv
module bunch_accept_delay
  import bunch_accept_delay_pkg::*;
#(
  parameter int PERIOD = 22,
  parameter int DEPTH  = 16,
  localparam int CW    = $clog2(DEPTH),
  localparam int FW    = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bunchStb,
  input  logic          decisionIn,
  input  logic [CW-1:0] coarseDelay,
  input  logic [FW-1:0] fineDelay,
  output logic          acceptOut
);

  ctlStrb_t      strb;
  logic [CW-1:0] tapSel;

  bunch_accept_delay_ctrl #(.PERIOD(PERIOD), .DEPTH(DEPTH)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bunchStb   (bunchStb),
    .coarseDelay(coarseDelay),
    .fineDelay  (fineDelay),
    .strb       (strb),
    .tapSel     (tapSel)
  );

  bunch_accept_delay_dpath #(.DEPTH(DEPTH)) dpath_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .decisionIn(decisionIn),
    .tapSel    (tapSel),
    .acceptOut (acceptOut)
  );

endmodule

// File: tb/bunch_accept_delay_tb_top.sv
module bunch_accept_delay_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PERIOD     = 22;
  localparam int MAX_FINE   = PERIOD - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bunchStb = 1'b0;
  logic       decisionIn = 1'b0;
  logic [3:0] coarseDelay = '0;
  logic [4:0] fineDelay = '0;
  logic       acceptOut;

  bunch_accept_delay dut_i (
    .clk(clk), .rst_n(rst_n), .bunchStb(bunchStb), .decisionIn(decisionIn),
    .coarseDelay(coarseDelay), .fineDelay(fineDelay), .acceptOut(acceptOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Reference model state, built from the requirements.
  bit decHist [0:255];
  int nStrb = 0;
  int cyc = 0;
  bit expOut = 1'b1;
  bit pend = 1'b0;
  int schedCyc = 0;
  bit schedVal = 1'b1;
  bit finished = 1'b0;

  // Each row: {decision, n, dt}
  localparam logic [9:0] VEC [16] = '{
    {1'b0, 4'd2, 5'd5},  {1'b1, 4'd2, 5'd5},  {1'b0, 4'd2, 5'd5},
    {1'b0, 4'd1, 5'd0},  {1'b1, 4'd0, 5'd0},  {1'b0, 4'd0, 5'd7},
    {1'b1, 4'd3, 5'd21}, {1'b0, 4'd3, 5'd21}, {1'b1, 4'd3, 5'd21},
    {1'b0, 4'd4, 5'd10}, {1'b1, 4'd4, 5'd10}, {1'b1, 4'd0, 5'd3},
    {1'b0, 4'd5, 5'd1},  {1'b1, 4'd5, 5'd1},  {1'b0, 4'd2, 5'd20},
    {1'b1, 4'd2, 5'd20}
  };

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: acceptOut=%b expected %b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(logic stb, logic dec, logic [3:0] n, logic [4:0] dt, string tag);
    int d;
    bit v;
    bunchStb = stb; decisionIn = dec; coarseDelay = n; fineDelay = dt;
    @(posedge clk);
    cyc++;
    if (pend && cyc == schedCyc) begin
      expOut = schedVal;
      pend = 1'b0;
    end
    if (stb) begin
      d = (int'(dt) > MAX_FINE) ? MAX_FINE : int'(dt);
      decHist[nStrb] = dec;
      v = (nStrb >= int'(n)) ? decHist[nStrb - int'(n)] : 1'b1;
      nStrb++;
      if (d == 0) expOut = v;
      else begin
        pend = 1'b1; schedCyc = cyc + d; schedVal = v;
      end
    end
    #1 check(tag, acceptOut, expOut);
    @(negedge clk);
  endtask

  task automatic bunch(logic dec, logic [3:0] n, logic [4:0] dt,
                       logic offDec, logic [3:0] offN, logic [4:0] offDt, string tag);
    step(1'b1, dec, n, dt, tag);
    repeat (PERIOD - 1) step(1'b0, offDec, offN, offDt, tag);
  endtask

  task automatic doReset();
    rst_n = 1'b0; bunchStb = 1'b0;
    nStrb = 0; expOut = 1'b1; pend = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R7", acceptOut, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL R3: watchdog expired (actual hung, expected completion)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();

    // Vector table: latency for both levels; off-strobe decision inverted (R3, R1).
    for (int i = 0; i < 16; i++) begin
      bunch(VEC[i][9], VEC[i][8:5], VEC[i][4:0], ~VEC[i][9], VEC[i][8:5], VEC[i][4:0], "R3");
    end

    // R1: decision toggled between strobes is ignored.
    bunch(1'b1, 4'd1, 5'd4, 1'b0, 4'd1, 5'd4, "R1");
    bunch(1'b0, 4'd1, 5'd4, 1'b1, 4'd1, 5'd4, "R1");
    bunch(1'b1, 4'd1, 5'd4, 1'b0, 4'd1, 5'd4, "R1");

    // R2: output holds between update edges.
    bunch(1'b0, 4'd0, 5'd11, 1'b1, 4'd0, 5'd11, "R2");
    bunch(1'b1, 4'd0, 5'd11, 1'b0, 4'd0, 5'd11, "R2");

    // R5: fine delay above the limit is clamped.
    bunch(1'b0, 4'd0, 5'd31, 1'b1, 4'd0, 5'd31, "R5");
    bunch(1'b1, 4'd0, 5'd22, 1'b0, 4'd0, 5'd22, "R5");
    bunch(1'b0, 4'd1, 5'd27, 1'b1, 4'd1, 5'd27, "R5");

    // R8: settings changed between strobes wait for the next strobe.
    bunch(1'b1, 4'd1, 5'd6, 1'b0, 4'd9, 5'd0, "R8");
    bunch(1'b0, 4'd1, 5'd6, 1'b1, 4'd0, 5'd15, "R8");
    bunch(1'b1, 4'd2, 5'd2, 1'b0, 4'd7, 5'd19, "R8");

    // R4: zero fine delay updates on the strobe edge.
    bunch(1'b0, 4'd0, 5'd0, 1'b1, 4'd0, 5'd0, "R4");
    bunch(1'b1, 4'd0, 5'd0, 1'b0, 4'd0, 5'd0, "R4");

    // R6: deepest coarse delay.
    for (int i = 0; i < 18; i++) begin
      bunch(logic'(i % 3 == 0), 4'd15, 5'd8, logic'(i % 3 != 0), 4'd15, 5'd8, "R6");
    end

    // R7: after a second reset, early taps read as accept.
    doReset();
    for (int i = 0; i < 7; i++) begin
      bunch(1'b0, 4'd5, 5'd3, 1'b1, 4'd5, 5'd3, "R7");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule